// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the decision core of an eight-input interrupt controller. It samples eight request lines and treats each one as edge-sensitive or level-sensitive according to a per-line mode bit. It keeps a pending register, an in-service register and a mask register, and it chooses one winning line. The search order starts at a rotation base and wraps around the line count. The block drives a single registered interrupt output toward the processor side.

When the processor acknowledges, the block reports the winning line index in that same cycle and updates its state. Without automatic end-of-interrupt, the winner is marked in service. With automatic end-of-interrupt, the winner is not marked in service, and the rotation base can optionally move to the line just past the winner. A new request interrupts only when it outranks the highest line already in service. Two mode inputs change how that in-service level is computed: one removes masked lines from it, and the other removes the cascade line when the block acts as master. Command decoding and bus access belong to the surrounding logic.

Top module: `rot_irq_resolver`

## Requirements
- R1: `rst` is synchronous and active high. It clears the pending, in-service, mask and last-level registers and sets the rotation base to 0. After reset, `irq_out` is 0 and `ack_line` reads 7.
- R2: The candidate set is the pending register with the masked lines removed. A line whose bit is 1 in the mask register never wins and never raises `irq_out`. The mask register loads `mask_in` on every clock.
- R3: The search visits line (k + base) mod 8 for k = 0 up to 7, and the first candidate found wins. When a winner exists, `ack_line` gives its index combinationally from the current state.
- R4: A candidate wins only if its search position is strictly lower than the search position of the highest-priority in-service line. A line whose priority is equal to or lower than that in-service level is held off.
- R5: When `special_mask` is 1, in-service lines whose mask bit is 1 are left out of the in-service level.
- R6: When `special_nest` and `is_master` are both 1, in-service line 2 is left out of the in-service level. If either input is 0, line 2 is counted as usual.
- R7: For a line whose `level_mode` bit is 1, the pending bit equals the level that was sampled on the previous clock.
- R8: For a line whose `level_mode` bit is 0, the pending bit is set only when the line is sampled high after it was last sampled low. The bit stays set after the line falls, until an acknowledge clears it.
- R9: An acknowledge that has a winner and `auto_eoi` = 0 sets the winner's in-service bit. An acknowledge clears the winner's pending bit only when that line is edge-sensitive.
- R10: An acknowledge that has a winner and `auto_eoi` = 1 leaves the in-service register unchanged. If `rotate_on_aeoi` is also 1, the rotation base becomes (winner + 1) mod 8.
- R11: `irq_out` is registered. It shows, one clock later, whether a winner existed in the previous cycle.
- R12: An acknowledge with no winner reports `ack_line` = 7 and leaves the pending, in-service and base state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_lines | input | 8 | Raw request lines |
| level_mode | input | 8 | Per-line trigger mode: 1 = level, 0 = edge |
| mask_in | input | 8 | Mask value, loaded into the mask register every clock |
| auto_eoi | input | 1 | Acknowledge does not set an in-service bit |
| rotate_on_aeoi | input | 1 | Automatic end-of-interrupt also rotates the base |
| special_mask | input | 1 | Masked in-service lines are left out of the in-service level |
| special_nest | input | 1 | Leave the cascade line out of the in-service level (master only) |
| is_master | input | 1 | The block is the master of a cascade |
| ack | input | 1 | Single-cycle acknowledge strobe |
| irq_out | output | 1 | Registered interrupt request |
| ack_line | output | 3 | Winning line index, or 7 when there is no winner |

## Verification
On every cycle, the assertions check local facts. The winner is always an unmasked pending line. It is not in service unless the nesting exception applies. Level lines follow their sampled input, and rising edges are captured. Each kind of acknowledge changes the in-service register and the base exactly as specified. The end-to-end ordering can only be shown by the bench scenarios: which line wins after a rotation, how one in-service line holds off lower-priority requests, how the two mode inputs change that in-service level, and that a held-high edge line does not request again. The bench's per-cycle reference comparison of `irq_out` and `ack_line` covers all of these.

// File: rtl/rot_irq_pkg.sv
`timescale 1ns/1ps
package rot_irq_pkg;

   // Operating mode bits gathered for the resolver core
   typedef struct packed {
      logic aeoi;
      logic rot_aeoi;
      logic smask;
      logic snest;
      logic master;
   } irq_mode_t;

endpackage

// File: rtl/irq_line_capture.sv
`timescale 1ns/1ps
module irq_line_capture #(
   parameter int LINES = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [LINES-1:0] lines_in,
   input  logic [LINES-1:0] level_mode,
   input  logic [LINES-1:0] ack_clr,
   output logic [LINES-1:0] pend
);

   logic [LINES-1:0] last_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend   <= '0;
         last_q <= '0;
      end else begin
         last_q <= lines_in;
         for (int i = 0; i < LINES; i++) begin
            if (level_mode[i])
               pend[i] <= lines_in[i];
            else if (lines_in[i] && !last_q[i])
               pend[i] <= 1'b1;
            else if (ack_clr[i])
               pend[i] <= 1'b0;
         end
      end
   end

   // R7
   level_follow_chk: assert property (@(posedge clk) disable iff (rst)
      !rst |=> ((pend & $past(level_mode)) == ($past(lines_in) & $past(level_mode))));

   // R8
   edge_capture_chk: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (($past(lines_in) & ~$past(last_q) & ~$past(level_mode) & ~pend) == '0));

endmodule

// File: rtl/irq_rot_scan.sv
`timescale 1ns/1ps
module irq_rot_scan #(
   parameter int LINES = 8
) (
   input  logic [LINES-1:0]         vec,
   input  logic [$clog2(LINES)-1:0] base,
   output logic [$clog2(LINES):0]   pos
);

   localparam int IDX_W = $clog2(LINES);
   localparam logic [IDX_W:0] NONE = (IDX_W+1)'(LINES);

   // Lowest search position whose rotated line is set; NONE if empty
   always_comb begin
      logic [IDX_W-1:0] idx;
      pos = NONE;
      for (int k = LINES - 1; k >= 0; k--) begin
         idx = IDX_W'(k) + base;
         if (vec[idx])
            pos = (IDX_W+1)'(k);
      end
   end

endmodule

// File: rtl/rot_irq_resolver.sv
`timescale 1ns/1ps
module rot_irq_resolver
   import rot_irq_pkg::*;
#(
   parameter int LINES        = 8,
   parameter int CASCADE_LINE = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [LINES-1:0]         irq_lines,
   input  logic [LINES-1:0]         level_mode,
   input  logic [LINES-1:0]         mask_in,
   input  logic                     auto_eoi,
   input  logic                     rotate_on_aeoi,
   input  logic                     special_mask,
   input  logic                     special_nest,
   input  logic                     is_master,
   input  logic                     ack,
   output logic                     irq_out,
   output logic [$clog2(LINES)-1:0] ack_line
);

   localparam int IDX_W = $clog2(LINES);
   localparam logic [LINES-1:0] ONE = {{(LINES-1){1'b0}}, 1'b1};
   localparam logic [IDX_W-1:0] SPURIOUS = IDX_W'(LINES - 1);

   if ((LINES < 2) || ((LINES & (LINES - 1)) != 0)) begin : g_bad_lines
      $error("LINES must be a power of two and at least 2");
   end
   if (CASCADE_LINE >= LINES) begin : g_bad_casc
      $error("CASCADE_LINE must be below LINES, or negative to disable");
   end

   irq_mode_t        mode;
   logic [LINES-1:0] pend, imr_q, isr_q, cand, svc_masked, svc_eff;
   logic [LINES-1:0] win_hot, ack_clr;
   logic [IDX_W-1:0] base_q, win_line;
   logic [IDX_W:0]   cand_pos, svc_pos;
   logic             win_valid, take;

   assign mode = '{aeoi: auto_eoi, rot_aeoi: rotate_on_aeoi, smask: special_mask,
                   snest: special_nest, master: is_master};

   irq_line_capture #(.LINES(LINES)) u_capture (
      .clk        (clk),
      .rst        (rst),
      .lines_in   (irq_lines),
      .level_mode (level_mode),
      .ack_clr    (ack_clr),
      .pend       (pend)
   );

   assign cand       = pend & ~imr_q;
   assign svc_masked = mode.smask ? (isr_q & ~imr_q) : isr_q;

   if (CASCADE_LINE >= 0) begin : g_casc
      localparam logic [LINES-1:0] CASC_BIT = ONE << CASCADE_LINE;
      assign svc_eff = (mode.snest && mode.master) ? (svc_masked & ~CASC_BIT) : svc_masked;
   end else begin : g_nocasc
      assign svc_eff = svc_masked;
   end

   irq_rot_scan #(.LINES(LINES)) u_cand_scan (
      .vec  (cand),
      .base (base_q),
      .pos  (cand_pos)
   );

   irq_rot_scan #(.LINES(LINES)) u_svc_scan (
      .vec  (svc_eff),
      .base (base_q),
      .pos  (svc_pos)
   );

   assign win_valid = cand_pos < svc_pos;
   assign win_line  = cand_pos[IDX_W-1:0] + base_q;
   assign win_hot   = ONE << win_line;
   assign ack_line  = win_valid ? win_line : SPURIOUS;
   assign take      = ack && win_valid;
   assign ack_clr   = take ? (win_hot & ~level_mode) : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         imr_q   <= '0;
         isr_q   <= '0;
         base_q  <= '0;
         irq_out <= 1'b0;
      end else begin
         imr_q   <= mask_in;
         irq_out <= win_valid;
         if (take) begin
            if (mode.aeoi) begin
               if (mode.rot_aeoi)
                  base_q <= win_line + IDX_W'(1);
            end else begin
               isr_q <= isr_q | win_hot;
            end
         end
      end
   end

   // R2
   win_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
      win_valid |-> !imr_q[win_line]);

   // R3
   win_pending_chk: assert property (@(posedge clk) disable iff (rst)
      win_valid |-> pend[win_line]);

   // R4
   win_not_in_service_chk: assert property (@(posedge clk) disable iff (rst)
      (win_valid && !(special_nest && is_master)) |-> !isr_q[win_line]);

   // R9
   svc_set_chk: assert property (@(posedge clk) disable iff (rst)
      (ack && win_valid && !auto_eoi) |=> isr_q[$past(win_line)]);

   // R10
   aeoi_keeps_svc_chk: assert property (@(posedge clk) disable iff (rst)
      (ack && auto_eoi) |=> (isr_q == $past(isr_q)));

   // R10
   aeoi_rotate_chk: assert property (@(posedge clk) disable iff (rst)
      (ack && win_valid && auto_eoi && rotate_on_aeoi) |=> ((base_q - $past(win_line)) == IDX_W'(1)));

   // R12
   spurious_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (ack && !win_valid) |=> ((isr_q == $past(isr_q)) && (base_q == $past(base_q))));

endmodule

// File: tb/test_rot_irq_resolver.sv
`timescale 1ns/1ps
module test_rot_irq_resolver;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] lines = '0, lvl = '0, mask = '0;
   logic       aeoi = 1'b0, rot = 1'b0, smask = 1'b0, snest = 1'b0, mstr = 1'b0, ack = 1'b0;
   logic       irq_out;
   logic [2:0] ack_line;

   int  checks = 0, fails = 0;
   bit  armed = 0, done = 0;
   int  m_irr, m_isr, m_imr, m_last, m_base;
   bit  m_irq;

   always #2 clk = ~clk;

   rot_irq_resolver i_rot_irq_resolver (
      .clk(clk), .rst(rst), .irq_lines(lines), .level_mode(lvl), .mask_in(mask),
      .auto_eoi(aeoi), .rotate_on_aeoi(rot), .special_mask(smask),
      .special_nest(snest), .is_master(mstr), .ack(ack),
      .irq_out(irq_out), .ack_line(ack_line)
   );

   function automatic int m_scan(int v, int b);
      for (int k = 0; k < 8; k++)
         if (((v >> ((k + b) % 8)) & 1) != 0) return k;
      return 8;
   endfunction

   function automatic int m_winner();
      int pc, ps, s;
      pc = m_scan(m_irr & ~m_imr & 255, m_base);
      if (pc == 8) return -1;
      s = m_isr;
      if (smask) s = s & ~m_imr;
      if (snest && mstr) s = s & ~4;
      ps = m_scan(s & 255, m_base);
      return (pc < ps) ? (pc + m_base) % 8 : -1;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Reference model, advanced on every clock
   always @(posedge clk) begin
      int w;
      if (rst) begin
         m_irr = 0; m_isr = 0; m_imr = 0; m_last = 0; m_base = 0; m_irq = 0;
         armed = 1;
      end else begin
         w = m_winner();
         m_irq = (w >= 0);
         if (ack && w >= 0) begin
            if (aeoi) begin
               if (rot) m_base = (w + 1) % 8;
            end else begin
               m_isr = m_isr | (1 << w);
            end
            if (!lvl[w]) m_irr = m_irr & ~(1 << w);
         end
         for (int i = 0; i < 8; i++) begin
            if (lvl[i]) begin
               if (lines[i]) m_irr = m_irr | (1 << i);
               else m_irr = m_irr & ~(1 << i);
            end else if (lines[i] && ((m_last >> i) & 1) == 0) begin
               m_irr = m_irr | (1 << i);
            end
         end
         m_last = int'(lines);
         m_imr  = int'(mask);
      end
   end

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      int w;
      #1;
      if (armed && !rst && !done) begin
         w = m_winner();
         check("R11 model irq_out", int'(irq_out), int'(m_irq));
         check("R3 model ack_line", int'(ack_line), (w < 0) ? 7 : w);
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst = 1; lines = 0; lvl = 0; mask = 0;
      aeoi = 0; rot = 0; smask = 0; snest = 0; mstr = 0; ack = 0;
      repeat (2) @(negedge clk);
      rst = 0;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R11 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      // Reset state and edge capture, blocking, special mask
      do_reset();
      #1;
      check("R1 irq_out after reset", int'(irq_out), 0);
      check("R1 ack_line after reset", int'(ack_line), 7);
      @(negedge clk); lines = 8'h28;
      @(negedge clk); #1;
      check("R11 irq_out not yet raised", int'(irq_out), 0);
      check("R3 lowest position wins", int'(ack_line), 3);
      @(negedge clk); lines = 8'h00; ack = 1; #1;
      check("R11 irq_out raised one clock later", int'(irq_out), 1);
      @(negedge clk); ack = 0; #1;
      check("R4 lower line held off by in-service", int'(ack_line), 7);
      @(negedge clk); mask = 8'h08; smask = 1; #1;
      check("R4 irq_out drops while held off", int'(irq_out), 0);
      @(negedge clk); #1;
      check("R5 masked in-service ignored", int'(ack_line), 5);
      check("R8 edge request held after fall", int'(ack_line), 5);
      @(negedge clk); smask = 0; lines = 8'h02; #1;
      check("R4 blocked again without special mask", int'(ack_line), 7);
      @(negedge clk); #1;
      check("R4 higher line preempts in-service", int'(ack_line), 1);

      // Level versus edge under automatic end-of-interrupt
      do_reset();
      @(negedge clk); lvl = 8'h02; aeoi = 1; lines = 8'h42;
      @(negedge clk); ack = 1; #1;
      check("R7 level line pending", int'(ack_line), 1);
      @(negedge clk); ack = 0; lines = 8'h40; #1;
      check("R10 no in-service after auto acknowledge", int'(ack_line), 1);
      check("R9 level pending kept after acknowledge", int'(ack_line), 1);
      @(negedge clk); ack = 1; #1;
      check("R7 level pending follows fall", int'(ack_line), 6);
      @(negedge clk); ack = 0; #1;
      check("R9 edge pending cleared, held line not re-requested", int'(ack_line), 7);

      // Rotation on automatic end-of-interrupt
      do_reset();
      @(negedge clk); aeoi = 1; rot = 1; lines = 8'h11;
      @(negedge clk); ack = 1; #1;
      check("R3 base zero winner", int'(ack_line), 0);
      @(negedge clk); ack = 0; lines = 8'h10; #1;
      check("R10 next line after rotation", int'(ack_line), 4);
      @(negedge clk); lines = 8'h11;
      @(negedge clk); ack = 1; #1;
      check("R10 rotated base ranks line 4 above line 0", int'(ack_line), 4);
      @(negedge clk); ack = 0; #1;
      check("R10 line 0 after second rotation", int'(ack_line), 0);

      // Special fully nested on the cascade line
      do_reset();
      @(negedge clk); mstr = 1; snest = 1; lines = 8'h04;
      @(negedge clk); ack = 1; #1;
      check("R3 cascade line wins", int'(ack_line), 2);
      @(negedge clk); ack = 0; lines = 8'h00;
      @(negedge clk); lines = 8'h04;
      @(negedge clk); #1;
      check("R6 cascade line re-enters while in service", int'(ack_line), 2);
      @(negedge clk); snest = 0; #1;
      check("R6 nesting off blocks re-entry", int'(ack_line), 7);
      @(negedge clk); snest = 1; mstr = 0; #1;
      check("R6 non-master blocks re-entry", int'(ack_line), 7);
      @(negedge clk); mstr = 1; #1;
      check("R6 master with nesting re-enters", int'(ack_line), 2);

      // Masking and spurious acknowledge
      do_reset();
      @(negedge clk); mask = 8'h08; lines = 8'h08;
      @(negedge clk); ack = 1; #1;
      check("R2 masked line does not win", int'(ack_line), 7);
      check("R12 spurious acknowledge index", int'(ack_line), 7);
      @(negedge clk); ack = 0; mask = 8'h00; #1;
      check("R2 masked line keeps irq_out low", int'(irq_out), 0);
      @(negedge clk); #1;
      check("R12 pending survives spurious acknowledge", int'(ack_line), 3);

      @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule